// File: doc/BRIEF.md
# Serial-to-Parallel Frame Assembler with Frame Strobe

The block sits behind a clock-and-data recovery stage. It receives one recovered serial bit per cycle of the bit clock and groups the bits into frames. Each frame is 20 bits long, or 24 bits long when the wide mode is chosen. A frame is delivered as a 20-bit data word. In wide mode the frame also carries a separate 4-bit control field. Each frame also comes with two per-frame flags.

A frame strobe marks the framing for downstream logic. It goes low on every frame boundary and goes high again halfway through the frame. Frame alignment is set by the release of reset: the first bit sampled after reset is bit 0 of the first frame.

Delivered frames come out through a fixed two-frame pipeline. A two-bit status value comes from outside the block. The block samples it once every 128 frames and holds it steady in between.

Top module: `frame_deser`

## Requirements
- R1: While reset is high, on the next clock `data_o`, `ctrl_o`, `wide_flag_o`, `valid_o` and `stat_o` are all zero and `strb_o` is high.
- R2: A frame is 20 bit-clock cycles long when its size select was 0 and 24 cycles long when it was 1. `strb_o` falls on the clock edge that samples the last bit of each frame.
- R3: `strb_o` rises on the edge that samples bit index L/2-1 of a frame of length L (index 9 or 11). It stays high through the rest of the frame and stays low from the frame start up to that point.
- R4: Bits enter least-significant first. In a 24-bit frame, bits 0-3 form `ctrl_o[3:0]` and bits 4-23 form `data_o[19:0]`. In a 20-bit frame, bits 0-19 form `data_o`, and `ctrl_o` is 0.
- R5: Frame k (counted from 0 after reset) appears on the outputs at the boundary that closes frame k+2. The outputs change only on that edge, and stay unchanged for the rest of the frame.
- R6: `wide_sel` is sampled only during reset and on the boundary edge. A change in the middle of a frame does not alter that frame's length; it applies from the next frame.
- R7: `stat_o` loads `stat_in` on the boundary where the internal 7-bit frame counter wraps from 127 to 0. That is the 128th, 256th, ... boundary after reset. It holds its value at every other time.
- R8: `wide_flag_o` is 1 when the delivered frame was 24 bits long. `valid_o` goes to 1 with the first delivered frame and stays 1 until reset.
- R9: After reset is released, the first boundary comes 20 or 24 sampled bits later, per the `wide_sel` value during reset. During that first frame `strb_o` stays high until that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Recovered serial data bit |
| wide_sel | input | 1 | Frame size select: 0 = 20 bits, 1 = 24 bits |
| stat_in | input | 2 | Status value to sample every 128 frames |
| data_o | output | 20 | Delivered data word |
| ctrl_o | output | 4 | Delivered control field (zero for 20-bit frames) |
| strb_o | output | 1 | Frame strobe: falls on boundary, rises mid-frame |
| wide_flag_o | output | 1 | Delivered frame was 24 bits long |
| valid_o | output | 1 | Output holds a received frame |
| stat_o | output | 2 | Held status value |

## Verification
The bench builds the block with its default parameters: 20-bit data, a 4-bit control field, two frames of latency and a 128-frame status period. At these values a run of 256 narrow frames (about 5,100 bit clocks) covers two status reloads. It also covers the hold between them when the input changes. The size select is flipped in the middle of every frame, so any early sampling would break the frame timing. Mixed sequences of 20- and 24-bit frames show the size change at each boundary, the control-field zeroing, and the wide flag following each frame through the pipeline.

// File: rtl/deser_pkg.sv
package deser_pkg;

  typedef enum logic {
    FRM_NARROW = 1'b0,
    FRM_WIDE   = 1'b1
  } frm_size_e;

  function automatic int unsigned frame_len(input frm_size_e sz,
                                            input int unsigned data_w,
                                            input int unsigned ctrl_w);
    return (sz == FRM_WIDE) ? data_w + ctrl_w : data_w;
  endfunction

endpackage

// File: rtl/deser_bitcount.sv
module deser_bitcount
  import deser_pkg::*;
#(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned CTRL_W = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wide_sel,
  output logic      bound_o,
  output frm_size_e size_o,
  output logic      strb_o
);
  localparam int unsigned LEN_N = DATA_W;
  localparam int unsigned LEN_W = DATA_W + CTRL_W;
  localparam int unsigned CW    = $clog2(LEN_W);
  localparam logic [CW-1:0] LAST_N = CW'(LEN_N - 1);
  localparam logic [CW-1:0] LAST_W = CW'(LEN_W - 1);
  localparam logic [CW-1:0] MID_N  = CW'(LEN_N / 2 - 1);
  localparam logic [CW-1:0] MID_W  = CW'(LEN_W / 2 - 1);

  logic [CW-1:0] bit_idx;
  frm_size_e     size_q;
  logic          strb_q;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] mid_idx;

  always_comb begin
    last_idx = (size_q == FRM_WIDE) ? LAST_W : LAST_N;
    mid_idx  = (size_q == FRM_WIDE) ? MID_W  : MID_N;
  end

  assign bound_o = (bit_idx == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      size_q  <= frm_size_e'(wide_sel);
      strb_q  <= 1'b1;
    end else if (bound_o) begin
      bit_idx <= '0;
      size_q  <= frm_size_e'(wide_sel);
      strb_q  <= 1'b0;
    end else begin
      bit_idx <= bit_idx + 1'b1;
      if (bit_idx == mid_idx) strb_q <= 1'b1;
    end
  end

  assign size_o = size_q;
  assign strb_o = strb_q;

endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
  parameter int unsigned FULL_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [FULL_W-1:0] word_o
);
  logic [FULL_W-1:0] shreg;

  assign word_o = {ser_in, shreg[FULL_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= word_o;
  end

endmodule

// File: rtl/deser_pipe.sv
module deser_pipe
  import deser_pkg::*;
#(
  parameter int unsigned DATA_W     = 20,
  parameter int unsigned CTRL_W     = 4,
  parameter int unsigned LAT_FRAMES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  frm_size_e                size_in,
  input  logic [DATA_W+CTRL_W-1:0] word_in,
  output logic [DATA_W-1:0]        data_o,
  output logic [CTRL_W-1:0]        ctrl_o,
  output logic                     wide_o,
  output logic                     valid_o
);
  localparam int unsigned FULL_W = DATA_W + CTRL_W;
  localparam int unsigned DEPTH  = LAT_FRAMES + 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_st
    logic [DATA_W-1:0] d;
    logic [CTRL_W-1:0] c;
    logic              w;
    logic              v;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          d <= '0; c <= '0; w <= 1'b0; v <= 1'b0;
        end else if (adv) begin
          d <= word_in[FULL_W-1:CTRL_W];
          c <= (size_in == FRM_WIDE) ? word_in[CTRL_W-1:0] : '0;
          w <= (size_in == FRM_WIDE);
          v <= 1'b1;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          d <= '0; c <= '0; w <= 1'b0; v <= 1'b0;
        end else if (adv) begin
          d <= g_st[i-1].d;
          c <= g_st[i-1].c;
          w <= g_st[i-1].w;
          v <= g_st[i-1].v;
        end
      end
    end
  end

  assign data_o  = g_st[DEPTH-1].d;
  assign ctrl_o  = g_st[DEPTH-1].c;
  assign wide_o  = g_st[DEPTH-1].w;
  assign valid_o = g_st[DEPTH-1].v;

endmodule

// File: rtl/deser_status.sv
module deser_status #(
  parameter int unsigned STAT_W      = 2,
  parameter int unsigned STAT_PERIOD = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_o
);
  localparam int unsigned PW = $clog2(STAT_PERIOD);
  localparam logic [PW-1:0] WRAP_AT = PW'(STAT_PERIOD - 1);

  logic [PW-1:0]     fcnt;
  logic [STAT_W-1:0] stat_q;
  logic              wrap;

  assign wrap = (fcnt == WRAP_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt   <= '0;
      stat_q <= '0;
    end else if (adv) begin
      fcnt <= wrap ? '0 : fcnt + 1'b1;
      if (wrap) stat_q <= stat_in;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/frame_deser.sv
module frame_deser
  import deser_pkg::*;
#(
  parameter int unsigned DATA_W      = 20,
  parameter int unsigned CTRL_W      = 4,
  parameter int unsigned LAT_FRAMES  = 2,
  parameter int unsigned STAT_W      = 2,
  parameter int unsigned STAT_PERIOD = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              wide_sel,
  input  logic [STAT_W-1:0] stat_in,
  output logic [DATA_W-1:0] data_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              strb_o,
  output logic              wide_flag_o,
  output logic              valid_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam int unsigned FULL_W = DATA_W + CTRL_W;

  logic              bound;
  frm_size_e         size_cur;
  logic [FULL_W-1:0] word;

  deser_bitcount #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_cnt (
    .clk(clk), .rst(rst), .wide_sel(wide_sel),
    .bound_o(bound), .size_o(size_cur), .strb_o(strb_o)
  );

  deser_shifter #(.FULL_W(FULL_W)) u_shift (
    .clk(clk), .rst(rst), .ser_in(ser_in), .word_o(word)
  );

  deser_pipe #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .LAT_FRAMES(LAT_FRAMES)) u_pipe (
    .clk(clk), .rst(rst), .adv(bound), .size_in(size_cur), .word_in(word),
    .data_o(data_o), .ctrl_o(ctrl_o), .wide_o(wide_flag_o), .valid_o(valid_o)
  );

  deser_status #(.STAT_W(STAT_W), .STAT_PERIOD(STAT_PERIOD)) u_stat (
    .clk(clk), .rst(rst), .adv(bound), .stat_in(stat_in), .stat_o(stat_o)
  );

endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned CTRL_W = 4,
  parameter int unsigned STAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              strb_o,
  input logic              wide_flag_o,
  input logic              valid_o,
  input logic [STAT_W-1:0] stat_o
);
  localparam int unsigned LEN_N = DATA_W;
  localparam int unsigned LEN_W = DATA_W + CTRL_W;
  localparam int unsigned GW    = $clog2(LEN_W) + 2;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                 gap <= '0;
    else if ($fell(strb_o))  gap <= GW'(1);
    else if (gap != GMAX)    gap <= gap + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (strb_o && data_o == '0 && ctrl_o == '0 && !wide_flag_o && !valid_o && stat_o == '0));

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(strb_o) |-> (gap == GW'(LEN_N) || gap == GW'(LEN_W)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$fell(strb_o) |-> ($stable(data_o) && $stable(ctrl_o) && $stable(wide_flag_o)));

  assert_narrow_ctrl_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !wide_flag_o |-> ctrl_o == '0);

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(strb_o) |-> $stable(stat_o));

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(valid_o) |-> valid_o);

endmodule

bind frame_deser deser_checker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .data_o(data_o), .ctrl_o(ctrl_o), .strb_o(strb_o),
  .wide_flag_o(wide_flag_o), .valid_o(valid_o), .stat_o(stat_o)
);

// File: tb/tb_frame_deser.sv
module tb_frame_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0;
  logic        wide_sel = 1'b0;
  logic [1:0]  stat_in = 2'b00;
  logic [19:0] data_o;
  logic [3:0]  ctrl_o;
  logic        strb_o, wide_flag_o, valid_o;
  logic [1:0]  stat_o;

  frame_deser dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .wide_sel(wide_sel), .stat_in(stat_in),
    .data_o(data_o), .ctrl_o(ctrl_o), .strb_o(strb_o), .wide_flag_o(wide_flag_o),
    .valid_o(valid_o), .stat_o(stat_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          nfr;
  bit          cur_wide;
  bit          first_frm;
  logic [1:0]  exp_stat;
  logic [19:0] last_data;
  logic [19:0] hd [0:299];
  logic [3:0]  hc [0:299];
  logic        hw [0:299];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] pat_d(input int k);
    logic [31:0] t;
    t = 32'h9E3779B1 * 32'(k + 3);
    return t[26:7];
  endfunction

  task automatic do_reset(input bit w0);
    @(negedge clk);
    rst = 1'b1; wide_sel = w0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "strobe", 32'(strb_o), 32'd1);
    chk("R1", "data", 32'(data_o), 32'd0);
    chk("R1", "ctrl", 32'(ctrl_o), 32'd0);
    chk("R1", "flags", {30'd0, wide_flag_o, valid_o}, 32'd0);
    chk("R1", "status", 32'(stat_o), 32'd0);
    rst = 1'b0;
    nfr = 0; cur_wide = w0; first_frm = 1'b1; exp_stat = 2'b00; last_data = '0;
  endtask

  // Starts and ends on a falling clock edge. nxt is the size of the next frame.
  task automatic send_frame(input string tag, input bit nxt,
                            input logic [19:0] d, input logic [3:0] c);
    int len, half;
    logic [23:0] bits;
    len  = cur_wide ? 24 : 20;
    half = len / 2;
    bits = cur_wide ? {d, c} : {4'd0, d};
    for (int i = 0; i < len; i++) begin
      ser_in = bits[i];
      if (i == 5)       wide_sel = ~cur_wide;   // mid-frame flip, R6
      if (i == len - 1) wide_sel = nxt;
      @(posedge clk); #1;
      if (i == len - 1)
        chk(first_frm ? "R9" : "R2", "strobe at last bit", 32'(strb_o), 32'd0);
      else if (i >= half - 1)
        chk("R3", "strobe second half", 32'(strb_o), 32'd1);
      else
        chk("R3", "strobe first half", 32'(strb_o), first_frm ? 32'd1 : 32'd0);
      if (i == half - 1)
        chk("R5", "data held mid-frame", 32'(data_o), 32'(last_data));
      @(negedge clk);
    end
    hd[nfr] = d; hc[nfr] = cur_wide ? c : 4'd0; hw[nfr] = cur_wide;
    if (nfr % 128 == 127) exp_stat = stat_in;
    if (nfr >= 2) begin
      chk(tag, "data", 32'(data_o), 32'(hd[nfr-2]));
      chk("R4", "ctrl", 32'(ctrl_o), 32'(hc[nfr-2]));
      chk("R8", "wide flag", 32'(wide_flag_o), 32'(hw[nfr-2]));
      chk("R8", "valid", 32'(valid_o), 32'd1);
    end else begin
      chk(tag, "data empty", 32'(data_o), 32'd0);
      chk("R8", "valid empty", 32'(valid_o), 32'd0);
    end
    chk("R7", "status", 32'(stat_o), 32'(exp_stat));
    last_data = data_o;
    nfr++;
    cur_wide = nxt;
    first_frm = 1'b0;
  endtask

  task automatic test_reset();
    do_reset(1'b0);
  endtask

  task automatic test_narrow();
    do_reset(1'b0);
    send_frame("R5", 1'b0, 20'h00001, 4'h0);
    send_frame("R5", 1'b0, 20'h80000, 4'h0);
    for (int k = 0; k < 4; k++) send_frame("R4", 1'b0, pat_d(k), 4'hF);
    send_frame("R4", 1'b0, 20'hFFFFF, 4'hA);
    send_frame("R4", 1'b0, 20'h00000, 4'h5);
    send_frame("R4", 1'b0, 20'h00000, 4'h0);
  endtask

  task automatic test_wide();
    do_reset(1'b1);
    send_frame("R5", 1'b1, 20'h00001, 4'h1);
    send_frame("R5", 1'b1, 20'h80000, 4'h8);
    for (int k = 0; k < 4; k++) send_frame("R4", 1'b1, pat_d(k + 10), 4'(k * 5 + 3));
    send_frame("R4", 1'b1, 20'h00000, 4'h0);
    send_frame("R4", 1'b1, 20'h00000, 4'h0);
  endtask

  task automatic test_mixed();
    do_reset(1'b0);
    for (int k = 0; k < 10; k++)
      send_frame("R6", (k % 3) != 0, pat_d(k + 40), 4'(k + 9));
    send_frame("R6", 1'b0, 20'h12345, 4'h6);
    send_frame("R6", 1'b0, 20'h0, 4'h0);
    send_frame("R6", 1'b0, 20'h0, 4'h0);
  endtask

  task automatic test_status();
    do_reset(1'b0);
    stat_in = 2'b10;
    for (int k = 0; k < 128; k++) send_frame("R5", 1'b0, pat_d(k), 4'h0);
    chk("R7", "first reload", 32'(stat_o), 32'd2);
    stat_in = 2'b01;
    for (int k = 0; k < 127; k++) send_frame("R5", 1'b0, pat_d(k + 200), 4'h0);
    chk("R7", "held before second reload", 32'(stat_o), 32'd2);
    send_frame("R5", 1'b0, 20'h0, 4'h0);
    chk("R7", "second reload", 32'(stat_o), 32'd1);
  endtask

  initial begin
    test_reset();
    test_narrow();
    test_wide();
    test_mixed();
    test_status();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule